// File: doc/BRIEF.md
# Instruction Line Fill Buffer

This block sits between an instruction fetch unit, a one-word-per-cycle flash array and the tag/data arrays of an instruction cache whose lines hold four 32-bit words. When a fetch misses both the cache and the buffer, the block reads the missed word from flash in that same cycle. It then uses every later cycle in which the fetch unit leaves the flash idle to read the remaining words of that line, one word per cycle, wrapping inside the line. The words gathered this way are kept in a four-entry buffer, and fetches that match a collected word are served straight from the buffer.

A line goes to the cache arrays through a single write port that carries one valid bit per word. A complete line is written in the first cycle in which the cache array is not being read, so the write never competes with a fetch. If a new miss arrives before the line is complete, the words collected so far are written as they stand, in the miss cycle, and the buffer starts over on the new line. Fetch timing therefore never changes. The way that receives a written line is chosen by a tree pseudo-LRU kept for each set. That state is updated on every cache hit and on every line write.

Top module: `line_fill_buf`

## Requirements
- R1: During and right after reset, with no fetch pending, buf_hit_o, flash_re_o and lw_en_o are all 0. The pseudo-LRU state of every set is cleared.
- R2: A fetch is active when fetch_req_i=1 and iq_hit_i=0. It is a miss when it is active and neither cache_hit_i nor buf_hit_o is set. In a miss cycle, flash_re_o=1 and flash_addr_o equals fetch_addr_i. The flash word arrives on flash_rdata_i in the next cycle and is stored in the buffer entry given by address bits [1:0].
- R3: An active fetch whose line address (bits above bit 1) equals the buffered line, and whose word has been collected (including a word arriving that cycle), gives buf_hit_o=1 with buf_rdata_o set to that word. It is not a miss, whatever cache_hit_i says.
- R4: In each cycle without a miss while fewer than four words of the buffered line have been requested, the block issues one flash read at the next word offset ((previous offset + 1) mod 4) of the same line. It never issues more than three such reads per line.
- R5: When all four words are held, the line is written with lw_valid_o=4'b1111 in the first cycle in which no active fetch is served by the cache (cache_hit_i=1 without buf_hit_o). Until that cycle the buffer keeps serving buffer hits.
- R6: A miss while the buffer holds part of a line writes that line in the same cycle. Bit i of lw_valid_o is set only for collected word offsets i, so earlier valid words of that cache line are dropped. The buffer then restarts with the new miss word.
- R7: lw_en_o is never 1 in a cycle in which an active fetch is served by the cache.
- R8: With 4 ways, each set holds bits root, left and right, all 0 after reset. The victim is 0/1 (by left) when root=0, and 2/3 (by right) when root=1. An access to way w sets root=(w<2), and sets left=(w==0) if w<2, otherwise right=(w==2). The access is a line write to lw_way_o, or a cache hit at the fetch index using cache_hit_way_i. lw_way_o shows the victim of the written set.
- R9: A fetch request with iq_hit_i=1 is not active. It gives no buffer hit and no miss, and its cycle counts as idle for prefetch.
- R10: On a line write, lw_index_o is line-address bits [IDX_W-1:0], lw_tag_o is the remaining upper line-address bits, and word offset i is carried on lw_data_o[32*i+31:32*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch unit wants a word |
| fetch_addr_i | input | AW | Word address of the fetch |
| iq_hit_i | input | 1 | Instruction queue already holds the word; the fetch is not active |
| cache_hit_i | input | 1 | Cache array hit for the fetch |
| cache_hit_way_i | input | WAY_W | Way that hit in the cache |
| buf_hit_o | output | 1 | Fetch served from the fill buffer |
| buf_rdata_o | output | 32 | Buffered word for a buffer hit |
| flash_re_o | output | 1 | Flash read strobe |
| flash_addr_o | output | AW | Flash word address |
| flash_rdata_i | input | 32 | Flash word, valid the cycle after a read |
| lw_en_o | output | 1 | Line write strobe to the tag/data arrays |
| lw_way_o | output | WAY_W | Way written |
| lw_index_o | output | IDX_W | Set index written |
| lw_tag_o | output | TAG_W | Tag written |
| lw_valid_o | output | 4 | Per-word valid mask written |
| lw_data_o | output | 128 | Line data, word i at bits 32*i+31:32*i |

## Verification
The fill path is tried with four kinds of fetch stream. Sequential fetches with idle gaps show whether prefetch wraps inside the line and whether buffer hits replace flash reads. Back-to-back misses to different lines expose the partial valid masks and the merge of a word arriving in the miss cycle. Random addresses with mostly cache hits test whether full-line writes are held back for as long as the array is being read. Mixed queue hits and random cache-hit ways check that idle cycles are recognised and that the tree replacement state follows each access.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LINE_WORDS = 4;
  localparam int unsigned OFF_W      = 2;
  typedef logic [WORD_W-1:0]     word_t;
  typedef logic [LINE_WORDS-1:0] wmask_t;
  typedef logic [OFF_W-1:0]      off_t;
endpackage

// File: rtl/lfb_buffer.sv
module lfb_buffer
  import lfb_pkg::*;
#(
  parameter int unsigned LINE_W = 14
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         land_i,
  input  off_t                         land_off_i,
  input  word_t                        land_data_i,
  input  logic                         act_i,
  input  logic [LINE_W-1:0]            line_i,
  input  logic                         look_i,
  input  logic [LINE_W-1:0]            look_line_i,
  input  off_t                         look_off_i,
  output wmask_t                       view_val_o,
  output logic [LINE_WORDS*WORD_W-1:0] view_data_o,
  output logic                         hit_o,
  output word_t                        hit_data_o
);
  wmask_t val_q;
  word_t  data_q [LINE_WORDS];
  word_t  vw     [LINE_WORDS];

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
    logic sel;
    assign sel = land_i && (land_off_i == off_t'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[i]  <= 1'b0;
        data_q[i] <= '0;
      end else begin
        if (sel) data_q[i] <= land_data_i;
        if (clear_i)  val_q[i] <= 1'b0;
        else if (sel) val_q[i] <= 1'b1;
      end
    end

    // word arriving this cycle is visible at once
    assign view_val_o[i] = val_q[i] | sel;
    assign vw[i]         = sel ? land_data_i : data_q[i];
    assign view_data_o[i*WORD_W +: WORD_W] = vw[i];
  end

  assign hit_o      = look_i && act_i && (look_line_i == line_i) && view_val_o[look_off_i];
  assign hit_data_o = vw[look_off_i];
endmodule

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
  import lfb_pkg::*;
#(
  parameter int unsigned AW = 16,
  localparam int unsigned LINE_W = AW - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [AW-1:0]     fetch_addr_i,
  input  logic              iq_hit_i,
  input  logic              cache_hit_i,
  input  logic              buf_hit_i,
  input  wmask_t            view_val_i,
  output logic              look_o,
  output logic              miss_o,
  output logic              cache_use_o,
  output logic              commit_o,
  output logic              flash_re_o,
  output logic [AW-1:0]     flash_addr_o,
  output logic              act_o,
  output logic [LINE_W-1:0] line_o,
  output logic              land_o,
  output off_t              land_off_o
);
  localparam logic [2:0] ALL_REQ = 3'(LINE_WORDS);

  logic              act_q, pend_q;
  logic [LINE_W-1:0] line_q;
  off_t              poff_q, noff_q;
  logic [2:0]        iss_q;
  logic              full, pf;

  assign look_o      = fetch_req_i && !iq_hit_i;
  assign miss_o      = look_o && !buf_hit_i && !cache_hit_i;
  assign cache_use_o = look_o && cache_hit_i && !buf_hit_i;
  assign full        = act_q && (&view_val_i);
  // full line waits for a cycle without an array read
  assign commit_o    = act_q && (|view_val_i) && (miss_o || (full && !cache_use_o));
  assign pf          = act_q && !miss_o && (iss_q < ALL_REQ) && !commit_o;

  assign flash_re_o   = miss_o || pf;
  assign flash_addr_o = miss_o ? fetch_addr_i : {line_q, noff_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      line_q <= '0;
      poff_q <= '0;
      noff_q <= '0;
      iss_q  <= '0;
    end else if (miss_o) begin
      act_q  <= 1'b1;
      line_q <= fetch_addr_i[AW-1:OFF_W];
      pend_q <= 1'b1;
      poff_q <= fetch_addr_i[OFF_W-1:0];
      noff_q <= fetch_addr_i[OFF_W-1:0] + off_t'(1);
      iss_q  <= 3'd1;
    end else if (commit_o) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      iss_q  <= '0;
    end else if (pf) begin
      pend_q <= 1'b1;
      poff_q <= noff_q;
      noff_q <= noff_q + off_t'(1);
      iss_q  <= iss_q + 3'd1;
    end else begin
      pend_q <= 1'b0;
    end
  end

  assign act_o      = act_q;
  assign line_o     = line_q;
  assign land_o     = pend_q;
  assign land_off_o = poff_q;
endmodule

// File: rtl/lfb_plru.sv
module lfb_plru #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [WAY_W-1:0] upd_way_i,
  output logic [WAY_W-1:0] victim_o
);
  if (WAYS == 1) begin : g_direct
    assign victim_o = '0;
  end else begin : g_tree
    localparam int unsigned LVL = $clog2(WAYS);
    // heap-ordered nodes 1..WAYS-1, bit 0 spare
    logic [WAYS-1:0] tree_q [SETS];
    logic [WAYS-1:0] rrow, nrow;

    always_comb begin
      int node;
      rrow = tree_q[rd_idx_i];
      node = 1;
      for (int l = 0; l < LVL; l++) node = 2 * node + int'(rrow[WAY_W'(node)]);
      victim_o = WAY_W'(node - int'(WAYS));
    end

    always_comb begin
      int node;
      logic [WAY_W-1:0] tw;
      nrow = tree_q[upd_idx_i];
      node = 1;
      tw   = upd_way_i;
      for (int l = 0; l < LVL; l++) begin
        nrow[WAY_W'(node)] = ~tw[WAY_W-1];
        node = 2 * node + int'(tw[WAY_W-1]);
        tw   = tw << 1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (upd_i) begin
        tree_q[upd_idx_i] <= nrow;
      end
    end
  end
endmodule

// File: rtl/line_fill_buf.sv
module line_fill_buf
  import lfb_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned WAYS  = 4,
  localparam int unsigned LINE_W = AW - OFF_W,
  localparam int unsigned TAG_W  = LINE_W - IDX_W,
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fetch_req_i,
  input  logic [AW-1:0]                fetch_addr_i,
  input  logic                         iq_hit_i,
  input  logic                         cache_hit_i,
  input  logic [WAY_W-1:0]             cache_hit_way_i,
  output logic                         buf_hit_o,
  output logic [WORD_W-1:0]            buf_rdata_o,
  output logic                         flash_re_o,
  output logic [AW-1:0]                flash_addr_o,
  input  logic [WORD_W-1:0]            flash_rdata_i,
  output logic                         lw_en_o,
  output logic [WAY_W-1:0]             lw_way_o,
  output logic [IDX_W-1:0]             lw_index_o,
  output logic [TAG_W-1:0]             lw_tag_o,
  output logic [LINE_WORDS-1:0]        lw_valid_o,
  output logic [LINE_WORDS*WORD_W-1:0] lw_data_o
);
  logic              look, miss, cache_use, commit, act, land;
  logic [LINE_W-1:0] line;
  off_t              land_off;
  wmask_t            view_val;
  logic [WAY_W-1:0]  victim;

  lfb_ctrl #(.AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_req_i  (fetch_req_i),
    .fetch_addr_i (fetch_addr_i),
    .iq_hit_i     (iq_hit_i),
    .cache_hit_i  (cache_hit_i),
    .buf_hit_i    (buf_hit_o),
    .view_val_i   (view_val),
    .look_o       (look),
    .miss_o       (miss),
    .cache_use_o  (cache_use),
    .commit_o     (commit),
    .flash_re_o   (flash_re_o),
    .flash_addr_o (flash_addr_o),
    .act_o        (act),
    .line_o       (line),
    .land_o       (land),
    .land_off_o   (land_off)
  );

  lfb_buffer #(.LINE_W(LINE_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (miss || commit),
    .land_i      (land),
    .land_off_i  (land_off),
    .land_data_i (flash_rdata_i),
    .act_i       (act),
    .line_i      (line),
    .look_i      (look),
    .look_line_i (fetch_addr_i[AW-1:OFF_W]),
    .look_off_i  (fetch_addr_i[OFF_W-1:0]),
    .view_val_o  (view_val),
    .view_data_o (lw_data_o),
    .hit_o       (buf_hit_o),
    .hit_data_o  (buf_rdata_o)
  );

  lfb_plru #(.SETS(1 << IDX_W), .WAYS(WAYS)) u_plru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (line[IDX_W-1:0]),
    .upd_i     (commit || cache_use),
    .upd_idx_i (commit ? line[IDX_W-1:0] : fetch_addr_i[OFF_W +: IDX_W]),
    .upd_way_i (commit ? victim : cache_hit_way_i),
    .victim_o  (victim)
  );

  assign lw_en_o    = commit;
  assign lw_way_o   = victim;
  assign lw_index_o = line[IDX_W-1:0];
  assign lw_tag_o   = line[LINE_W-1:IDX_W];
  assign lw_valid_o = view_val;
endmodule

// File: rtl/lfb_checker.sv
module lfb_checker #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fetch_req_i,
  input logic [AW-1:0] fetch_addr_i,
  input logic          iq_hit_i,
  input logic          cache_hit_i,
  input logic          buf_hit_o,
  input logic          flash_re_o,
  input logic [AW-1:0] flash_addr_o,
  input logic          lw_en_o,
  input logic [3:0]    lw_valid_o
);
  logic          act_f, miss_f, arr_rd;
  logic          seen_q;
  logic [AW-3:0] mline_q;

  assign act_f  = fetch_req_i && !iq_hit_i;
  assign miss_f = act_f && !cache_hit_i && !buf_hit_o;
  assign arr_rd = act_f && cache_hit_i && !buf_hit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      mline_q <= '0;
    end else if (miss_f) begin
      seen_q  <= 1'b1;
      mline_q <= fetch_addr_i[AW-1:2];
    end
  end

  assert_miss_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_f |-> (flash_re_o && flash_addr_o == fetch_addr_i));

  assert_pf_in_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_re_o && !miss_f) |-> (seen_q && flash_addr_o[AW-1:2] == mline_q));

  assert_full_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lw_en_o && !miss_f) |-> (lw_valid_o == 4'hF));

  assert_nonempty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_en_o |-> (lw_valid_o != 4'h0));

  assert_no_collide_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rd |-> !lw_en_o);

  assert_iq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iq_hit_i |-> !buf_hit_o);
endmodule

bind line_fill_buf lfb_checker #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_req_i  (fetch_req_i),
  .fetch_addr_i (fetch_addr_i),
  .iq_hit_i     (iq_hit_i),
  .cache_hit_i  (cache_hit_i),
  .buf_hit_o    (buf_hit_o),
  .flash_re_o   (flash_re_o),
  .flash_addr_o (flash_addr_o),
  .lw_en_o      (lw_en_o),
  .lw_valid_o   (lw_valid_o)
);

// File: tb/sim_line_fill_buf.sv
module sim_line_fill_buf;
  localparam int AW = 16, IDX_W = 4, WAYS = 4;
  localparam int TAG_W = AW - 2 - IDX_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fetch_req_i = 1'b0, iq_hit_i = 1'b0, cache_hit_i = 1'b0;
  logic [AW-1:0] fetch_addr_i = '0;
  logic [1:0] cache_hit_way_i = '0;
  logic [31:0] flash_rdata_i = '0;
  logic buf_hit_o, flash_re_o, lw_en_o;
  logic [31:0] buf_rdata_o;
  logic [AW-1:0] flash_addr_o;
  logic [1:0] lw_way_o;
  logic [IDX_W-1:0] lw_index_o;
  logic [TAG_W-1:0] lw_tag_o;
  logic [3:0] lw_valid_o;
  logic [127:0] lw_data_o;

  always #2 clk = ~clk;

  line_fill_buf #(.AW(AW), .IDX_W(IDX_W), .WAYS(WAYS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_req_i(fetch_req_i), .fetch_addr_i(fetch_addr_i),
    .iq_hit_i(iq_hit_i), .cache_hit_i(cache_hit_i), .cache_hit_way_i(cache_hit_way_i),
    .buf_hit_o(buf_hit_o), .buf_rdata_o(buf_rdata_o), .flash_re_o(flash_re_o),
    .flash_addr_o(flash_addr_o), .flash_rdata_i(flash_rdata_i), .lw_en_o(lw_en_o),
    .lw_way_o(lw_way_o), .lw_index_o(lw_index_o), .lw_tag_o(lw_tag_o),
    .lw_valid_o(lw_valid_o), .lw_data_o(lw_data_o));

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  bit m_act, m_pend;
  int m_line, m_poff, m_noff, m_iss;
  bit [3:0] m_val;
  bit [31:0] m_dat [4];
  bit pr [16], pl [16], prr [16];
  bit prev_fre;
  int prev_fa;

  function automatic bit [31:0] fmem(int a);
    return (32'(a) * 32'h0100_0193) ^ 32'hA5C3_0000 ^ 32'(a << 3);
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic int victim(int s);
    if (!pr[s]) return pl[s] ? 1 : 0;
    return prr[s] ? 3 : 2;
  endfunction

  function automatic void touch(int s, int w);
    pr[s] = (w < 2);
    if (w < 2) pl[s] = (w == 0);
    else prr[s] = (w == 2);
  endfunction

  task automatic step(bit req, int addr, bit iq, bit ch, int cw);
    bit [3:0] vv;
    bit [31:0] vd [4];
    bit act, bh, miss, cuse, full, lw, pf, fre;
    int line, off, fa, idx, way;
    @(negedge clk);
    fetch_req_i = req; fetch_addr_i = AW'(addr); iq_hit_i = iq;
    cache_hit_i = ch; cache_hit_way_i = 2'(cw);
    flash_rdata_i = prev_fre ? fmem(prev_fa) : 32'h0;
    #1;
    vv = m_val;
    if (m_pend) vv[m_poff] = 1'b1;
    for (int i = 0; i < 4; i++) vd[i] = (m_pend && m_poff == i) ? fmem(prev_fa) : m_dat[i];
    line = addr >> 2; off = addr & 3;
    act  = req && !iq;
    bh   = act && m_act && line == m_line && vv[off];
    miss = act && !bh && !ch;
    cuse = act && ch && !bh;
    full = m_act && vv == 4'hF;
    lw   = m_act && vv != 0 && (miss || (full && !cuse));
    pf   = m_act && !miss && m_iss < 4 && !lw;
    fre  = miss || pf;
    fa   = miss ? addr : m_line * 4 + m_noff;
    idx  = m_line % 16;
    way  = victim(idx);

    check(buf_hit_o == bh, "R3 buf_hit", 128'(buf_hit_o), 128'(bh));
    if (bh) check(buf_rdata_o == vd[off], "R3 buf_rdata", 128'(buf_rdata_o), 128'(vd[off]));
    if (req && iq) check(!buf_hit_o, "R9 iq_hit gives no buffer hit", 128'(buf_hit_o), 128'(0));
    check(flash_re_o == fre, miss ? "R2 flash_re" : (act ? "R4 flash_re" : "R9 flash_re"),
          128'(flash_re_o), 128'(fre));
    if (fre) check(flash_addr_o == AW'(fa), miss ? "R2 flash_addr" : "R4 flash_addr",
                   128'(flash_addr_o), 128'(fa));
    check(lw_en_o == lw, miss ? "R6 lw_en" : "R5 lw_en", 128'(lw_en_o), 128'(lw));
    if (cuse) check(!lw_en_o, "R7 no write on array read", 128'(lw_en_o), 128'(0));
    if (lw) begin
      check(lw_valid_o == vv, miss ? "R6 lw_valid" : "R5 lw_valid", 128'(lw_valid_o), 128'(vv));
      check(lw_index_o == IDX_W'(idx), "R10 lw_index", 128'(lw_index_o), 128'(idx));
      check(lw_tag_o == TAG_W'(m_line / 16), "R10 lw_tag", 128'(lw_tag_o), 128'(m_line / 16));
      check(lw_way_o == 2'(way), "R8 lw_way", 128'(lw_way_o), 128'(way));
      for (int i = 0; i < 4; i++)
        if (vv[i]) check(lw_data_o[32*i +: 32] == vd[i], "R10 lw_data",
                         128'(lw_data_o[32*i +: 32]), 128'(vd[i]));
    end

    @(posedge clk);
    if (lw) touch(idx, way);
    else if (cuse) touch((addr >> 2) % 16, cw);
    m_val = vv;
    for (int i = 0; i < 4; i++) m_dat[i] = vd[i];
    if (miss) begin
      m_act = 1; m_line = line; m_val = 0; m_pend = 1;
      m_poff = off; m_noff = (off + 1) % 4; m_iss = 1;
    end else if (lw) begin
      m_act = 0; m_val = 0; m_pend = 0; m_iss = 0;
    end else if (pf) begin
      m_pend = 1; m_poff = m_noff; m_noff = (m_noff + 1) % 4; m_iss++;
    end else begin
      m_pend = 0;
    end
    prev_fre = fre; prev_fa = fa;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a;
    void'($urandom(7));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!buf_hit_o && !flash_re_o && !lw_en_o, "R1 reset outputs",
          128'({buf_hit_o, flash_re_o, lw_en_o}), 128'(0));
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0);
    check(!buf_hit_o && !flash_re_o && !lw_en_o, "R1 idle after reset",
          128'({buf_hit_o, flash_re_o, lw_en_o}), 128'(0));

    // directed: miss mid-line, prefetch wraps, full write on idle (R2 R4 R5 R8)
    step(1, 16'h0041, 0, 0, 0);
    repeat (4) step(0, 0, 0, 0, 0);
    // buffer hit after refill, queue hit ignored (R3 R9)
    step(1, 16'h0050, 0, 0, 0);
    step(1, 16'h0052, 1, 0, 0);
    step(1, 16'h0051, 0, 1, 0);
    step(1, 16'h0053, 0, 1, 2);
    // full line held while array is read (R5 R7)
    repeat (3) step(1, 16'h0200, 0, 1, 1);
    step(0, 0, 0, 0, 0);
    // back-to-back misses: partial writes (R6)
    step(1, 16'h0010, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 16'h0023, 0, 0, 0);
    step(1, 16'h0037, 0, 0, 0);
    step(1, 16'h0110, 0, 0, 0);

    // sequential with gaps
    a = 16'h0300;
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 3 == 0) step(0, 0, 0, 0, 0);
      else begin
        step(1, a, ($urandom % 5) == 0, ($urandom % 4) == 0, $urandom % 4);
        a = (a + 1) & 16'hFFFF;
      end
    end
    // random addresses, mixed hits
    for (int n = 0; n < 4000; n++)
      step($urandom % 4 != 0, 16'h0400 + ($urandom % 96), ($urandom % 5) == 0,
           ($urandom % 2) == 0, $urandom % 4);
    // mostly array reads
    for (int n = 0; n < 3000; n++)
      step(1, $urandom % 4096, ($urandom % 10) == 0, ($urandom % 10) != 0, $urandom % 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule